// File: doc/BRIEF.md
# PCIe MSI Capture Controller

This block sits beside a PCIe root port and turns message-signalled interrupts into pending bits. Each inbound memory write is offered to it together with its 64-bit address and its data word. When the address equals the programmed 64-bit target, the data word is taken as a vector number in the range 0 to 255. That vector lands in one of eight banks of 32 pending bits, but only if software has enabled that vector.

Software programs the block through a plain word-wide register port. Writes are strobed and reads are combinational from the offset. Through this port it sets the target address, the per-bank enable and mask words, and it acknowledges vectors by writing ones to the pending words. One interrupt line summarises every pending vector that is not masked. Software watches this line for a rising edge, then scans the banks, acknowledging each vector before it services it. New vectors may arrive during the scan and are not lost.

Top module: `msi_capture_ctrl`

## Requirements
- R1: The target address low word is at offset 0x820 and the high word at 0x824. Both read back what was last written.
- R2: Bank g (0 to 7) has its enable word at 0x828 + 12*g, its mask word at 0x82C + 12*g and its pending word at 0x830 + 12*g. Enable and mask words read back what was last written.
- R3: A write with msi_valid high, an address equal to {high word, low word} and data d below 256 sets pending bit d mod 32 of bank d/32 at the next clock edge, provided that enable bit is 1.
- R4: A write whose address differs from the target in either the low or the high 32 bits changes no pending bit.
- R5: A data value of 256 or above sets no pending bit. In particular it does not wrap onto vector d mod 256.
- R6: A matching write to a vector whose enable bit is 0 leaves that pending bit clear.
- R7: Writing the pending word of a bank clears each bit written as 1 and leaves each bit written as 0 unchanged. Clearing one bit does not disturb a vector being set in the same cycle.
- R8: When a captured vector and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: irq_out is high exactly when some bank has a pending bit whose mask bit is 0. It follows the registered pending and mask state, with no further delay. Masking never changes a pending bit.
- R10: Reset (rst_n low, asynchronous) clears every address, enable, mask and pending bit and drops irq_out. Reads of unmapped or non-word-aligned offsets return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_valid | input | 1 | An inbound memory write is offered this cycle |
| msi_addr | input | 64 | Byte address of the inbound write |
| msi_data | input | 32 | Data word of the inbound write (vector number) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_out | output | 1 | Summary interrupt: any unmasked pending vector |

## Verification
A vector capture and a software write-one-to-clear can land on a pending word in the same clock cycle. This is the race a servicing handler meets when a device fires again during acknowledgement. The bench provokes it by raising msi_valid and the pending-word write strobe at the same falling edge, once aimed at the very bit being cleared and once at a neighbouring bit. After the next rising edge it reads the pending word and expects the captured bit set in both cases, with the cleared neighbour gone in the second.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_ADDR_LO,
    RK_ADDR_HI,
    RK_EN,
    RK_MASK,
    RK_STAT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] grp;
  } reg_sel_t;

  localparam logic [11:0] OFS_ADDR_LO   = 12'h820;
  localparam logic [11:0] OFS_ADDR_HI   = 12'h824;
  localparam logic [11:0] OFS_BANK_BASE = 12'h828;
  localparam int          BANK_STRIDE   = 12;

  // Offset decode: address words, then banks of three words each.
  function automatic reg_sel_t decode_offset(input logic [11:0] ofs, input int groups);
    reg_sel_t r;
    int       rel;
    r.kind = RK_NONE;
    r.grp  = '0;
    rel    = int'(ofs) - int'(OFS_BANK_BASE);
    if (ofs == OFS_ADDR_LO) begin
      r.kind = RK_ADDR_LO;
    end else if (ofs == OFS_ADDR_HI) begin
      r.kind = RK_ADDR_HI;
    end else if (ofs[1:0] == 2'b00 && rel >= 0 && rel < BANK_STRIDE * groups) begin
      r.grp = 8'(rel / BANK_STRIDE);
      case (rel % BANK_STRIDE)
        0:       r.kind = RK_EN;
        4:       r.kind = RK_MASK;
        default: r.kind = RK_STAT;
      endcase
    end
    return r;
  endfunction

  function automatic logic vec_in_range(input logic [31:0] d, input int unsigned total);
    return d < 32'(total);
  endfunction

  function automatic int unsigned group_of(input logic [31:0] d, input int unsigned lanes);
    return d / lanes;
  endfunction

  function automatic int unsigned lane_of(input logic [31:0] d, input int unsigned lanes);
    return d % lanes;
  endfunction

endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF-1:0]   wdata,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic [ADDR_W-1:0] target_q,
  output logic              hit
);
  localparam int HALF = ADDR_W / 2;

  logic [HALF-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end
  end

  assign target_q = {hi_q, lo_q};
  assign hit      = (probe_addr == target_q);
endmodule

// File: rtl/msi_vec_steer.sv
module msi_vec_steer
  import msi_cap_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int LANES  = 32,
  parameter int DATA_W = 32
) (
  input  logic              msi_valid,
  input  logic              addr_hit,
  input  logic [DATA_W-1:0] msi_data,
  output logic              accept,
  output logic [GRP_W-1:0]  evt_grp,
  output logic [LANE_W-1:0] evt_lane,
  output logic [VEC_W-1:0]  evt_idx
);
  localparam int TOTAL  = GROUPS * LANES;
  localparam int VEC_W  = $clog2(TOTAL);
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int LANE_W = $clog2(LANES);

  logic in_range;

  assign in_range = vec_in_range(msi_data, TOTAL);
  assign accept   = msi_valid && addr_hit && in_range;
  assign evt_grp  = GRP_W'(group_of(msi_data, LANES));
  assign evt_lane = LANE_W'(lane_of(msi_data, LANES));
  assign evt_idx  = msi_data[VEC_W-1:0];
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank #(
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             mask_we,
  input  logic             stat_we,
  input  logic [LANES-1:0] wdata,
  input  logic [LANES-1:0] set_req,
  output logic [LANES-1:0] en_q,
  output logic [LANES-1:0] mask_q,
  output logic [LANES-1:0] stat_q,
  output logic [LANES-1:0] set_eff,
  output logic             pend
);
  logic [LANES-1:0] clr_vec;
  logic [LANES-1:0] stat_d;

  assign set_eff = set_req & en_q;
  assign clr_vec = stat_we ? wdata : '0;
  // Capture has priority over acknowledge on the same bit.
  assign stat_d  = (stat_q & ~clr_vec) | set_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (en_we)   en_q   <= wdata;
      if (mask_we) mask_q <= wdata;
      stat_q <= stat_d;
    end
  end

  assign pend = |(stat_q & ~mask_q);
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int LANES  = 32,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 12,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_valid,
  input  logic [ADDR_W-1:0] msi_addr,
  input  logic [DATA_W-1:0] msi_data,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_out
);
  localparam int TOTAL  = GROUPS * LANES;
  localparam int VEC_W  = $clog2(TOTAL);
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int LANE_W = $clog2(LANES);
  localparam int HALF   = ADDR_W / 2;

  // Named internal events, visible to the bound checker.
  reg_sel_t          sel;
  logic              addr_hit;
  logic              evt_accept;
  logic [GRP_W-1:0]  evt_grp;
  logic [LANE_W-1:0] evt_lane;
  logic [VEC_W-1:0]  evt_idx;
  logic [ADDR_W-1:0] target_q;
  logic [TOTAL-1:0]  stat_all;
  logic [TOTAL-1:0]  en_all;
  logic [GROUPS-1:0] pend_vec;

  logic [LANES-1:0]  en_arr   [GROUPS];
  logic [LANES-1:0]  mask_arr [GROUPS];
  logic [LANES-1:0]  stat_arr [GROUPS];

  assign sel = decode_offset(12'(reg_addr), GROUPS);

  msi_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lo      (reg_we && sel.kind == RK_ADDR_LO),
    .wr_hi      (reg_we && sel.kind == RK_ADDR_HI),
    .wdata      (reg_wdata[HALF-1:0]),
    .probe_addr (msi_addr),
    .target_q   (target_q),
    .hit        (addr_hit)
  );

  msi_vec_steer #(.GROUPS(GROUPS), .LANES(LANES), .DATA_W(DATA_W)) u_steer (
    .msi_valid (msi_valid),
    .addr_hit  (addr_hit),
    .msi_data  (msi_data),
    .accept    (evt_accept),
    .evt_grp   (evt_grp),
    .evt_lane  (evt_lane),
    .evt_idx   (evt_idx)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_bank
    logic             hit_grp;
    logic             sel_grp;
    logic [LANES-1:0] set_req;
    logic [LANES-1:0] set_eff;

    assign hit_grp = evt_accept && (evt_grp == GRP_W'(g));
    assign set_req = hit_grp ? (LANES'(1) << evt_lane) : '0;
    assign sel_grp = reg_we && (sel.grp == 8'(g));

    msi_vec_bank #(.LANES(LANES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_we   (sel_grp && sel.kind == RK_EN),
      .mask_we (sel_grp && sel.kind == RK_MASK),
      .stat_we (sel_grp && sel.kind == RK_STAT),
      .wdata   (reg_wdata[LANES-1:0]),
      .set_req (set_req),
      .en_q    (en_arr[g]),
      .mask_q  (mask_arr[g]),
      .stat_q  (stat_arr[g]),
      .set_eff (set_eff),
      .pend    (pend_vec[g])
    );

    assign stat_all[g*LANES +: LANES] = stat_arr[g];
    assign en_all[g*LANES +: LANES]   = en_arr[g];
  end

  always_comb begin
    reg_rdata = '0;
    case (sel.kind)
      RK_ADDR_LO: reg_rdata = REG_W'(target_q[HALF-1:0]);
      RK_ADDR_HI: reg_rdata = REG_W'(target_q[ADDR_W-1:HALF]);
      RK_EN, RK_MASK, RK_STAT: begin
        for (int g = 0; g < GROUPS; g++) begin
          if (sel.grp == 8'(g)) begin
            if (sel.kind == RK_EN)        reg_rdata = REG_W'(en_arr[g]);
            else if (sel.kind == RK_MASK) reg_rdata = REG_W'(mask_arr[g]);
            else                          reg_rdata = REG_W'(stat_arr[g]);
          end
        end
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq_out = |pend_vec;
endmodule

// File: rtl/msi_capture_chk.sv
module msi_capture_chk #(
  parameter int TOTAL  = 256,
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              msi_valid,
  input logic [DATA_W-1:0] msi_data,
  input logic              irq_out,
  input logic              addr_hit,
  input logic              evt_accept,
  input logic [VEC_W-1:0]  evt_idx,
  input logic [TOTAL-1:0]  stat_all,
  input logic [TOTAL-1:0]  en_all
);
  // R3 and R8: an accepted, enabled vector is pending next cycle even under a clear.
  p_accept_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && en_all[evt_idx]) |=> stat_all[$past(evt_idx)]);

  // R4: an address miss never produces an accepted event.
  p_addr_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !addr_hit) |-> !evt_accept);

  // R5: out-of-range data never produces an accepted event.
  p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && msi_data >= DATA_W'(TOTAL)) |-> !evt_accept);

  // R6: a disabled vector stays clear when nothing else touches the banks.
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && !en_all[evt_idx] && !stat_all[evt_idx] && !reg_we)
      |=> !stat_all[$past(evt_idx)]);

  // R7: pending state moves only on a capture or a register write.
  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_accept && !reg_we) |=> $stable(stat_all));

  // R9: no pending vector means no interrupt.
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_all == '0) |-> !irq_out);
endmodule

bind msi_capture_ctrl msi_capture_chk #(
  .TOTAL  (TOTAL),
  .VEC_W  (VEC_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .msi_valid  (msi_valid),
  .msi_data   (msi_data),
  .irq_out    (irq_out),
  .addr_hit   (addr_hit),
  .evt_accept (evt_accept),
  .evt_idx    (evt_idx),
  .stat_all   (stat_all),
  .en_all     (en_all)
);

// File: tb/sim_msi_capture_ctrl.sv
module sim_msi_capture_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_valid = 1'b0;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit reported = 1'b0;

  localparam logic [63:0] TGT = 64'h0000_0001_A000_0000;

  msi_capture_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .msi_valid (msi_valid),
    .msi_addr  (msi_addr),
    .msi_data  (msi_data),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  always #2 clk = ~clk;

  // Expected offsets, computed the bench's own way.
  function automatic logic [11:0] en_ofs(input int g);   return 12'(2088 + g * 12); endfunction
  function automatic logic [11:0] mask_ofs(input int g); return 12'(2092 + g * 12); endfunction
  function automatic logic [11:0] stat_ofs(input int g); return 12'(2096 + g * 12); endfunction

  // op: 0 register write, 1 register read check, 2 inbound write
  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] ofs;
    logic [63:0] maddr;
    logic [31:0] val;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 24;
  localparam step_t TBL [NSTEP] = '{
    '{2'd0, 12'h820, 64'd0, 32'hA000_0000, 4'd1},
    '{2'd0, 12'h824, 64'd0, 32'h0000_0001, 4'd1},
    '{2'd1, 12'h820, 64'd0, 32'hA000_0000, 4'd1},   // R1
    '{2'd1, 12'h824, 64'd0, 32'h0000_0001, 4'd1},   // R1
    '{2'd0, 12'h828, 64'd0, 32'hFFFF_FFFF, 4'd2},
    '{2'd0, 12'h84C, 64'd0, 32'h0000_FFFF, 4'd2},
    '{2'd0, 12'h87C, 64'd0, 32'hFFFF_FFFF, 4'd2},
    '{2'd1, 12'h84C, 64'd0, 32'h0000_FFFF, 4'd2},   // R2
    '{2'd2, 12'h000, TGT,   32'd5,         4'd3},
    '{2'd1, 12'h830, 64'd0, 32'h0000_0020, 4'd3},   // R3 bank0 lane5
    '{2'd2, 12'h000, TGT,   32'd100,       4'd3},
    '{2'd1, 12'h854, 64'd0, 32'h0000_0010, 4'd3},   // R3 bank3 lane4
    '{2'd2, 12'h000, TGT,   32'd116,       4'd6},
    '{2'd1, 12'h854, 64'd0, 32'h0000_0010, 4'd6},   // R6 lane20 disabled
    '{2'd2, 12'h000, TGT,   32'd255,       4'd3},
    '{2'd1, 12'h884, 64'd0, 32'h8000_0000, 4'd3},   // R3 top vector
    '{2'd2, 12'h000, TGT,   32'd256,       4'd5},
    '{2'd1, 12'h830, 64'd0, 32'h0000_0020, 4'd5},   // R5 no wrap to lane0
    '{2'd2, 12'h000, 64'h0000_0001_A000_0004, 32'd6, 4'd4},
    '{2'd1, 12'h830, 64'd0, 32'h0000_0020, 4'd4},   // R4 low half miss
    '{2'd2, 12'h000, 64'h0000_0000_A000_0000, 32'd7, 4'd4},
    '{2'd1, 12'h830, 64'd0, 32'h0000_0020, 4'd4},   // R4 high half miss
    '{2'd0, 12'h830, 64'd0, 32'h0000_0000, 4'd7},
    '{2'd1, 12'h830, 64'd0, 32'h0000_0020, 4'd7}    // R7 zero leaves bit
  };

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] ofs, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ofs; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic msi_send(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  task automatic reg_check(input string tag, input logic [11:0] ofs, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = ofs;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic irq_check(input string tag, input logic exp);
    @(negedge clk);
    #1;
    check(tag, {31'd0, irq_out}, {31'd0, exp});
  endtask

  // Capture and acknowledge in one cycle.
  task automatic race(input int g, input logic [31:0] d, input logic [31:0] clr);
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = TGT; msi_data = d;
    reg_we = 1'b1; reg_addr = stat_ofs(g); reg_wdata = clr;
    @(negedge clk);
    msi_valid = 1'b0; reg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 irq in reset", {31'd0, irq_out}, 32'd0);
    rst_n = 1'b1;
    reg_check("R10 addr lo reset", 12'h820, 32'd0);
    reg_check("R10 addr hi reset", 12'h824, 32'd0);
    for (int g = 0; g < 8; g++) begin
      reg_check("R10 enable reset", en_ofs(g), 32'd0);
      reg_check("R10 mask reset", mask_ofs(g), 32'd0);
      reg_check("R10 status reset", stat_ofs(g), 32'd0);
    end
    irq_check("R10 irq after reset", 1'b0);

    for (int i = 0; i < NSTEP; i++) begin
      case (TBL[i].op)
        2'd0: reg_write(TBL[i].ofs, TBL[i].val);
        2'd1: reg_check($sformatf("R%0d table step %0d", TBL[i].req, i), TBL[i].ofs, TBL[i].val);
        default: msi_send(TBL[i].maddr, TBL[i].val);
      endcase
    end

    // R7: write-one clears only the bits written
    reg_write(12'h830, 32'h0000_0020);
    reg_check("R7 one clears", 12'h830, 32'd0);
    reg_check("R7 other bank untouched", 12'h854, 32'h0000_0010);

    // R9: summary interrupt versus masks (bank3 lane4 and bank7 lane31 pending)
    irq_check("R9 pending unmasked", 1'b1);
    reg_write(mask_ofs(3), 32'h0000_0010);
    irq_check("R9 one bank masked", 1'b1);
    reg_write(mask_ofs(7), 32'h8000_0000);
    irq_check("R9 all masked", 1'b0);
    reg_check("R9 mask keeps status", stat_ofs(7), 32'h8000_0000);
    reg_check("R2 mask readback", mask_ofs(7), 32'h8000_0000);
    reg_write(mask_ofs(3), 32'h0000_0000);
    irq_check("R9 unmasked again", 1'b1);
    reg_write(stat_ofs(3), 32'h0000_0010);
    irq_check("R9 drops when cleared", 1'b0);

    // R8: capture and clear on the same bit in one cycle
    msi_send(TGT, 32'd9);
    reg_check("R3 lane9 set", stat_ofs(0), 32'h0000_0200);
    race(0, 32'd9, 32'h0000_0200);
    reg_check("R8 set wins same bit", stat_ofs(0), 32'h0000_0200);
    race(0, 32'd10, 32'h0000_0200);
    reg_check("R7 R8 clear and set differ", stat_ofs(0), 32'h0000_0400);

    // R10: unmapped and unaligned offsets
    reg_write(12'h900, 32'hFFFF_FFFF);
    reg_check("R10 unmapped reads zero", 12'h900, 32'd0);
    reg_write(12'h82A, 32'h0000_0000);
    reg_check("R10 unaligned write ignored", 12'h828, 32'hFFFF_FFFF);
    reg_check("R10 unaligned reads zero", 12'h822, 32'd0);
    reg_check("R10 past last bank", 12'h888, 32'd0);

    // R10: reset in the middle of activity
    irq_check("R9 pending before reset", 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    reg_addr = stat_ofs(0);
    #1;
    check("R10 status cleared by reset", reg_rdata, 32'd0);
    check("R10 irq cleared by reset", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    reg_check("R10 enable cleared by reset", en_ofs(0), 32'd0);

    report();
    $finish;
  end
endmodule